// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame is kept, based on its identifier. It compares the identifier against a bank of eight programmable code bytes and eight mask bytes. A 2-bit filter mode splits that one bank into two wide filters, four medium filters or eight narrow filters, or closes the filter completely. When a frame passes, the block raises a one-cycle accept pulse. It also works out the index of the lowest-numbered filter that matched.

The index of each accepted frame is held in a small queue. A frame and its index travel together towards the receive buffer that the CPU sees. The visible hit index changes only when the surrounding receiver signals that a message has been moved into that buffer. At that moment the oldest queued index becomes visible. The filter mode can be changed only while the initialization request and the initialization acknowledge are both high.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, `filter_mode` is 2'b00, `hit_idx` is 0 and `frame_accept` is 0.
- R2: Mask bit semantics: a mask bit of 1 makes that identifier bit don't-care, and a mask bit of 0 requires the identifier bit to equal the code bit. Bank byte k is `acc_code[8k+7:8k]` / `acc_mask[8k+7:8k]`, and identifier byte i is `rx_id[8i+7:8i]`.
- R3: With mode 2'b00, filter n (0..1) compares identifier bytes 0..3 with bank bytes 4n..4n+3.
- R4: With mode 2'b01, filter n (0..3) compares identifier bytes 0..1 with bank bytes 2n..2n+1.
- R5: With mode 2'b10, filter n (0..7) compares identifier byte 0 with bank byte n.
- R6: With mode 2'b11, no frame is accepted and no index is queued.
- R7: When several filters match, the reported index is the lowest-numbered matching filter. It is a 3-bit binary value.
- R8: A write on `mode_wr` takes effect only when `init_req` and `init_ack` are both 1. Any other write leaves `filter_mode` unchanged.
- R9: `hit_idx` changes only on a cycle with `buf_load` and a non-empty queue. It then takes the oldest queued index, so indices come out in acceptance order.
- R10: `frame_accept` is high for exactly the one cycle after an accepted `frame_done`. It is low after a rejected frame and when no frame is presented.
- R11: Once the queue holds HQ_DEPTH (default 4) indices, a further matching frame is refused (`frame_accept` stays 0). The exception is a frame in the same cycle as a `buf_load`.
- R12: If `buf_load` and an accepted frame fall in the same cycle, `hit_idx` takes the old queue head and the new index is queued behind it. A `buf_load` on an empty queue leaves `hit_idx` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_id | input | 32 | Received identifier, byte 0 in bits 7:0 |
| frame_done | input | 1 | Strobe: `rx_id` holds a complete frame's identifier |
| acc_code | input | 64 | Eight acceptance code bytes |
| acc_mask | input | 64 | Eight mask bytes, 1 = don't care |
| mode_wr | input | 1 | Write strobe for the filter mode |
| mode_wdata | input | 2 | New filter mode |
| init_req | input | 1 | Initialization request |
| init_ack | input | 1 | Initialization acknowledge |
| buf_load | input | 1 | Strobe: a message moves into the CPU-visible buffer |
| frame_accept | output | 1 | One-cycle pulse: the last frame was accepted |
| hit_idx | output | 3 | Filter index of the message in the CPU-visible buffer |
| filter_mode | output | 2 | Current filter mode |

## Verification
Frame acceptance (a push into the index queue) and a buffer load (a pop from it) can land on the same clock edge. The bench provokes this twice. The first time the queue is full, and it checks that the new frame is still accepted because a slot opens in that same cycle. The second time the queue is empty, and it checks that `hit_idx` keeps its old value. After both cases, a following load must show the newly queued index, which confirms ordering across the overlap.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;

    localparam int ID_BYTES   = 4;
    localparam int BANK_BYTES = 8;
    localparam int HIT_W      = $clog2(BANK_BYTES);

    typedef enum logic [1:0] {
        FM_WIDE = 2'b00,
        FM_HALF = 2'b01,
        FM_BYTE = 2'b10,
        FM_SHUT = 2'b11
    } filt_mode_e;

endpackage

// File: rtl/acc_lane_match.sv
module acc_lane_match
    import can_acc_pkg::*;
#(
    parameter int IDB  = ID_BYTES,
    parameter int BNKB = BANK_BYTES
) (
    input  logic [8*IDB-1:0]  rx_id,
    input  logic [8*BNKB-1:0] code,
    input  logic [8*BNKB-1:0] mask,
    input  filt_mode_e        mode,
    output logic [BNKB-1:0]   lane_hit
);
    localparam int HALFB  = IDB / 2;
    localparam int WIDE_N = BNKB / IDB;
    localparam int HALF_N = BNKB / HALFB;

    logic [BNKB-1:0] ok_w, ok_h, ok_b;
    logic [BNKB-1:0] wide_hit, half_hit;

    // per bank byte: compare with the identifier byte each layout pairs it with
    for (genvar j = 0; j < BNKB; j++) begin : g_byte
        assign ok_w[j] = ((rx_id[8*(j % IDB) +: 8] ^ code[8*j +: 8]) & ~mask[8*j +: 8]) == 8'h00;
        assign ok_h[j] = ((rx_id[8*(j % HALFB) +: 8] ^ code[8*j +: 8]) & ~mask[8*j +: 8]) == 8'h00;
        assign ok_b[j] = ((rx_id[7:0] ^ code[8*j +: 8]) & ~mask[8*j +: 8]) == 8'h00;
    end

    for (genvar n = 0; n < BNKB; n++) begin : g_lane
        if (n < WIDE_N) begin : g_w
            assign wide_hit[n] = &ok_w[n*IDB +: IDB];
        end else begin : g_wn
            assign wide_hit[n] = 1'b0;
        end
        if (n < HALF_N) begin : g_h
            assign half_hit[n] = &ok_h[n*HALFB +: HALFB];
        end else begin : g_hn
            assign half_hit[n] = 1'b0;
        end
    end

    always_comb begin
        case (mode)
            FM_WIDE: lane_hit = wide_hit;
            FM_HALF: lane_hit = half_hit;
            FM_BYTE: lane_hit = ok_b;
            default: lane_hit = '0;
        endcase
    end
endmodule

// File: rtl/acc_low_pick.sv
module acc_low_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/acc_hit_queue.sv
module acc_hit_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 3,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } q_t;

    q_t q_d, q_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d = q_q;
        if (push) begin
            q_d.mem[q_q.wp] = din;
            q_d.wp          = step(q_q.wp);
        end
        if (pop) q_d.rp = step(q_q.rp);
        case ({push, pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head  = q_q.mem[q_q.rp];
    assign full  = (q_q.cnt == CW'(DEPTH));
    assign empty = (q_q.cnt == '0);

    // R11: a push into a full queue must be paired with a pop
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);
    // R12: popping an empty queue is never requested
    assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_acc_pkg::*;
#(
    parameter int HQ_DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [8*ID_BYTES-1:0]   rx_id,
    input  logic                    frame_done,
    input  logic [8*BANK_BYTES-1:0] acc_code,
    input  logic [8*BANK_BYTES-1:0] acc_mask,
    input  logic                    mode_wr,
    input  logic [1:0]              mode_wdata,
    input  logic                    init_req,
    input  logic                    init_ack,
    input  logic                    buf_load,
    output logic                    frame_accept,
    output logic [HIT_W-1:0]        hit_idx,
    output logic [1:0]              filter_mode
);
    typedef struct packed {
        filt_mode_e       mode;
        logic             accept;
        logic [HIT_W-1:0] hit;
    } st_t;

    st_t st_d, st_q;

    logic [BANK_BYTES-1:0] lane_hit;
    logic                  any_hit;
    logic [HIT_W-1:0]      low_idx;
    logic [HIT_W-1:0]      q_head;
    logic                  q_full, q_empty;
    logic                  pop, take;

    acc_lane_match #(.IDB(ID_BYTES), .BNKB(BANK_BYTES)) u_match (
        .rx_id    (rx_id),
        .code     (acc_code),
        .mask     (acc_mask),
        .mode     (st_q.mode),
        .lane_hit (lane_hit)
    );

    acc_low_pick #(.N(BANK_BYTES)) u_pick (
        .req (lane_hit),
        .any (any_hit),
        .idx (low_idx)
    );

    acc_hit_queue #(.DEPTH(HQ_DEPTH), .W(HIT_W)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take),
        .din   (low_idx),
        .pop   (pop),
        .head  (q_head),
        .full  (q_full),
        .empty (q_empty)
    );

    always_comb begin
        st_d = st_q;
        pop  = buf_load && !q_empty;
        take = frame_done && any_hit && (st_q.mode != FM_SHUT) && (!q_full || pop);
        if (mode_wr && init_req && init_ack) st_d.mode = filt_mode_e'(mode_wdata);
        st_d.accept = take;
        if (pop) st_d.hit = q_head;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: FM_WIDE, accept: 1'b0, hit: '0};
        else        st_q <= st_d;
    end

    assign frame_accept = st_q.accept;
    assign hit_idx      = st_q.hit;
    assign filter_mode  = st_q.mode;

    // R8: mode holds unless both initialization handshakes are high
    assert_mode_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_req && init_ack) |=> $stable(filter_mode));
    // R6: closed filter never flags an accept
    assert_shut_rejects_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (filter_mode == 2'b11) |=> !frame_accept);
    // R9: visible index moves only on a buffer load
    assert_hit_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_load |=> $stable(hit_idx));
    // R10: accept only follows a frame strobe
    assert_accept_after_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> !frame_accept);
endmodule

// File: tb/can_accept_filter_test.sv
`timescale 1ns/1ps
module can_accept_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rx_id = '0;
    logic        frame_done = 1'b0;
    logic [63:0] acc_code = 64'h80_00_22_11_44_33_22_11;
    logic [63:0] acc_mask = 64'h00_0F_00_00_00_00_00_00;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_wdata = '0;
    logic        init_req = 1'b0;
    logic        init_ack = 1'b0;
    logic        buf_load = 1'b0;
    logic        frame_accept;
    logic [2:0]  hit_idx;
    logic [1:0]  filter_mode;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_hit = '0;

    always #2.5 clk = ~clk;

    can_accept_filter uut (
        .clk(clk), .rst_n(rst_n), .rx_id(rx_id), .frame_done(frame_done),
        .acc_code(acc_code), .acc_mask(acc_mask), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .init_req(init_req), .init_ack(init_ack),
        .buf_load(buf_load), .frame_accept(frame_accept), .hit_idx(hit_idx),
        .filter_mode(filter_mode)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic [31:0] id;
        logic        acc;
        logic [2:0]  hit;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 32'h44332211, 1'b1, 3'd0},  // R3 filter 0
        '{2'b00, 32'h80072211, 1'b1, 3'd1},  // R3 filter 1, R2 masked nibble
        '{2'b00, 32'h800F2211, 1'b1, 3'd1},  // R2 all masked bits set
        '{2'b00, 32'h80102211, 1'b0, 3'd0},  // R2 unmasked bit differs
        '{2'b00, 32'h44332255, 1'b0, 3'd0},  // R3 no match
        '{2'b01, 32'hFFFF2211, 1'b1, 3'd0},  // R7 filters 0 and 2 overlap, R4 upper bytes ignored
        '{2'b01, 32'h00004433, 1'b1, 3'd1},  // R4
        '{2'b01, 32'h1234800A, 1'b1, 3'd3},  // R4 filter 3
        '{2'b01, 32'h00005555, 1'b0, 3'd0},  // R4 no match
        '{2'b10, 32'hFFFFFF44, 1'b1, 3'd3},  // R5
        '{2'b10, 32'h00000022, 1'b1, 3'd1},  // R7 filters 1 and 5 overlap
        '{2'b10, 32'h0000000C, 1'b1, 3'd6},  // R5 filter 6
        '{2'b10, 32'h00000080, 1'b1, 3'd7},  // R5 filter 7
        '{2'b10, 32'h00000099, 1'b0, 3'd0},  // R5 no match
        '{2'b11, 32'h44332211, 1'b0, 3'd0},  // R6
        '{2'b11, 32'h00000011, 1'b0, 3'd0}   // R6
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_mode(input logic [1:0] m, input logic rq, input logic ak);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = m; init_req = rq; init_ack = ak;
        @(negedge clk);
        mode_wr = 1'b0; init_req = 1'b0; init_ack = 1'b0;
    endtask

    task automatic send(input logic [31:0] id, input logic ld);
        @(negedge clk);
        rx_id = id; frame_done = 1'b1; buf_load = ld;
        @(negedge clk);
        frame_done = 1'b0; buf_load = 1'b0;
    endtask

    task automatic load();
        @(negedge clk);
        buf_load = 1'b1;
        @(negedge clk);
        buf_load = 1'b0;
    endtask

    initial begin
        #(5ns * 200000);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(filter_mode == 2'b00, "R1 mode", filter_mode, 0);
        chk(hit_idx == 3'd0, "R1 hit", hit_idx, 0);
        chk(frame_accept == 1'b0, "R1 accept", frame_accept, 0);
        rst_n = 1'b1;

        // vector walk
        for (int v = 0; v < NV; v++) begin
            write_mode(VECS[v].md, 1'b1, 1'b1);
            chk(filter_mode == VECS[v].md, "R8 mode set", filter_mode, VECS[v].md);
            send(VECS[v].id, 1'b0);
            chk(frame_accept == VECS[v].acc, $sformatf("R2-R7 accept vec %0d", v),
                frame_accept, VECS[v].acc);
            load();
            if (VECS[v].acc) exp_hit = VECS[v].hit;
            chk(hit_idx == exp_hit, $sformatf("R7 hit vec %0d", v), hit_idx, exp_hit);
        end

        // R8 writes without the full handshake are ignored
        write_mode(2'b10, 1'b1, 1'b1);
        write_mode(2'b00, 1'b1, 1'b0);
        chk(filter_mode == 2'b10, "R8 ack low", filter_mode, 2);
        write_mode(2'b01, 1'b0, 1'b1);
        chk(filter_mode == 2'b10, "R8 req low", filter_mode, 2);

        // R9 R10 hit delayed until load, FIFO order, accept is a pulse
        send(32'h44, 1'b0);
        chk(frame_accept == 1'b1, "R10 accept pulse", frame_accept, 1);
        chk(hit_idx == exp_hit, "R9 hit not yet moved", hit_idx, exp_hit);
        @(negedge clk);
        chk(frame_accept == 1'b0, "R10 pulse ends", frame_accept, 0);
        send(32'h80, 1'b0);
        send(32'h11, 1'b0);
        chk(hit_idx == exp_hit, "R9 hit still old", hit_idx, exp_hit);
        load(); chk(hit_idx == 3'd3, "R9 first load", hit_idx, 3);
        load(); chk(hit_idx == 3'd7, "R9 second load", hit_idx, 7);
        load(); chk(hit_idx == 3'd0, "R9 third load", hit_idx, 0);

        // R11 full queue refuses, unless a load shares the cycle
        send(32'h11, 1'b0);
        send(32'h22, 1'b0);
        send(32'h33, 1'b0);
        send(32'h44, 1'b0);
        chk(frame_accept == 1'b1, "R11 fourth fits", frame_accept, 1);
        send(32'h80, 1'b0);
        chk(frame_accept == 1'b0, "R11 full refuses", frame_accept, 0);
        send(32'h80, 1'b1);
        chk(frame_accept == 1'b1, "R11 full with load", frame_accept, 1);
        chk(hit_idx == 3'd0, "R12 load takes head", hit_idx, 0);
        load(); chk(hit_idx == 3'd1, "R11 drain 1", hit_idx, 1);
        load(); chk(hit_idx == 3'd2, "R11 drain 2", hit_idx, 2);
        load(); chk(hit_idx == 3'd3, "R11 drain 3", hit_idx, 3);
        load(); chk(hit_idx == 3'd7, "R11 drain 4", hit_idx, 7);

        // R12 empty queue: simultaneous frame and load keeps old hit
        send(32'h22, 1'b1);
        chk(frame_accept == 1'b1, "R12 accept", frame_accept, 1);
        chk(hit_idx == 3'd7, "R12 empty load ignored", hit_idx, 7);
        load(); chk(hit_idx == 3'd1, "R12 queued behind", hit_idx, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule